// File: doc/BRIEF.md
# Paged Memory Mapping Decoder

This block sits between a 16-bit CPU address bus and four memories: a boot ROM, a 32 KB work RAM, a 2 KB character RAM and a large video RAM. For every access it raises exactly one device select. It also gives the address inside that device and a write enable that is never raised for the ROM. The CPU address space is divided into sixteen 4 KB pages. Each page has an 8-bit map register. The register is written through the decoder itself, and the register chosen is the one whose page the write address falls in.

The decoder chooses among three mappings. The first is a fixed split: ROM below 0x8000, RAM above it, and the character RAM window at 0x7800–0x7FFF. The second is a flat 32 KB window onto video RAM, placed by the upper nibble of a high-resolution select register. The third remaps individual 4 KB pages into video RAM through the bit-inverted map registers. Opcode fetches never reach the character RAM. The two control lines (external-memory enable and keyboard DTR) and the high-resolution register are held in registers. The selects and the address are combinational from the current address and that registered state.

Top module: `page_map_decoder`

## Requirements
- R1: A map write (`map_wr`) loads `map_wdata` into the register of page `cpu_addr[15:12]`. The new value first affects decoding after the next rising clock edge, and during the write cycle the old value still applies.
- R2: After reset all map registers are 0x00, the high-resolution register is 0x00, external-memory enable is low and keyboard DTR is high. The decoder therefore starts in the fixed ROM/RAM split.
- R3: In the fixed split, an address below 0x8000 selects ROM (`dev_sel` bit 0) and an address of 0x8000 or above selects work RAM (`dev_sel` bit 1). In both cases `mem_addr = cpu_addr[14:0]`.
- R4: Outside an opcode fetch, addresses 0x7800–0x7FFF select the character RAM (`dev_sel` bit 2) with `mem_addr = cpu_addr[10:0]`. Address 0x77FF still selects ROM.
- R5: When `cpu_fetch` is high, the character RAM is never selected. A fetch in the fixed split at 0x7800–0x7FFF selects ROM.
- R6: With keyboard DTR low, an address below 0x8000 selects video RAM (`dev_sel` bit 3), including the character window. The address is `mem_addr = ({hires[7:4], 11'b0} | cpu_addr[14:0])`, masked to the video RAM size. Upper-half addresses still select work RAM.
- R7: With external-memory enable high and bit 7 of the page's map register set (inverted bit 7 clear), the page selects video RAM. The address is `((~reg[6:0]) << 12) | cpu_addr[11:0]`, masked. This rule covers all sixteen pages and takes priority over R6.
- R8: Every video RAM address is masked to `VRAM_AW` bits (default 17, 128 KB).
- R9: Exactly one bit of `dev_sel` is set in every cycle out of reset.
- R10: `mem_we` equals `cpu_wr` except when ROM is selected, in which case it is low.
- R11: Bits 3:0 of the high-resolution register (displayed area) have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_fetch | input | 1 | High during an opcode fetch |
| cpu_wr | input | 1 | High for a CPU memory write |
| map_wr | input | 1 | Load the map register of page `cpu_addr[15:12]` |
| map_wdata | input | 8 | Map register write data |
| hires_wr | input | 1 | Load the high-resolution select register |
| hires_wdata | input | 8 | High-resolution register data |
| xmem_in | input | 1 | External-memory enable level, registered each clock |
| kdtr_in | input | 1 | Keyboard DTR level, registered each clock |
| dev_sel | output | 4 | One-hot select: bit0 ROM, bit1 RAM, bit2 char RAM, bit3 video RAM |
| mem_addr | output | VRAM_AW | Address inside the selected device |
| mem_we | output | 1 | Write enable to the selected device |

## Verification
The bench checks the edges of the character window, where 0x77FF must stay ROM and 0x7800 and 0x7FFF must go to the character RAM. A decoder with an off-by-one window compare would send one of these to the wrong memory. It also checks opcode fetches inside that window: a decoder that ignored fetch would hand instruction reads to the character RAM. It checks the priority of per-page remap over the flat window, and the inversion of the map register together with the mask on the video address. A swapped priority, or a missing inversion or mask, would put data at a wrong video RAM page. A map write is sampled within its own cycle, so a decoder that forwarded the write data combinationally would be caught changing the mapping one cycle early.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

    typedef enum logic [1:0] {
        TGT_ROM = 2'd0,
        TGT_RAM = 2'd1,
        TGT_CHR = 2'd2,
        TGT_VID = 2'd3
    } tgt_e;

    localparam int SEL_W = 4;

    typedef struct packed {
        logic [7:0] hires;
        logic       xmem;
        logic       kdtr;
    } ctl_t;

endpackage

// File: rtl/pmd_map_regfile.sv
module pmd_map_regfile #(
    parameter int PAGES = 16,
    parameter int DW    = 8,
    localparam int IW   = $clog2(PAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cur
);

    logic [DW-1:0] regs_d [PAGES];
    logic [DW-1:0] regs_q [PAGES];

    always_comb begin
        for (int i = 0; i < PAGES; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (wr) begin
            regs_d[idx] = wdata;
        end
    end

    for (genvar g = 0; g < PAGES; g++) begin : g_page
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end
    end

    assign cur = regs_q[idx];

endmodule

// File: rtl/pmd_ctrl_regs.sv
module pmd_ctrl_regs
    import pmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hires_wr,
    input  logic [7:0] hires_wdata,
    input  logic       xmem_in,
    input  logic       kdtr_in,
    output ctl_t       ctl
);

    ctl_t st_d;
    ctl_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.xmem = xmem_in;
        st_d.kdtr = kdtr_in;
        if (hires_wr) begin
            st_d.hires = hires_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hires <= '0;
            st_q.xmem  <= 1'b0;
            st_q.kdtr  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl = st_q;

endmodule

// File: rtl/pmd_decode.sv
module pmd_decode
    import pmd_pkg::*;
#(
    parameter int VRAM_AW = 17
) (
    input  logic [15:0]        addr,
    input  logic               fetch,
    input  logic               wr,
    input  logic [7:0]         map_cur,
    input  ctl_t               ctl,
    output logic [SEL_W-1:0]   sel,
    output logic [VRAM_AW-1:0] maddr,
    output logic               we
);

    localparam int PG_W   = 19;
    localparam int FULL_W = (VRAM_AW > PG_W) ? VRAM_AW : PG_W;

    logic [7:0]        map_inv;
    logic              page_en;
    logic              low_half;
    logic              chr_win;
    logic [14:0]       flat_a;
    logic [PG_W-1:0]   paged_a;
    logic [FULL_W-1:0] vid_full;
    tgt_e              tgt;

    always_comb begin
        map_inv  = ~map_cur;
        page_en  = ~map_inv[7];
        low_half = ~addr[15];
        chr_win  = low_half && (addr[14:11] == 4'hF);
        flat_a   = {ctl.hires[7:4], 11'b0} | addr[14:0];
        paged_a  = {map_inv[6:0], addr[11:0]};
        vid_full = '0;

        if (ctl.xmem && page_en) begin
            tgt      = TGT_VID;
            vid_full = FULL_W'(paged_a);
        end else if (!ctl.kdtr && low_half) begin
            tgt      = TGT_VID;
            vid_full = FULL_W'(flat_a);
        end else if (chr_win && !fetch) begin
            tgt = TGT_CHR;
        end else if (low_half) begin
            tgt = TGT_ROM;
        end else begin
            tgt = TGT_RAM;
        end

        case (tgt)
            TGT_VID: maddr = vid_full[VRAM_AW-1:0];
            TGT_CHR: maddr = VRAM_AW'(addr[10:0]);
            default: maddr = VRAM_AW'(addr[14:0]);
        endcase

        sel = SEL_W'(1) << tgt;
        we  = wr && (tgt != TGT_ROM);
    end

endmodule

// File: rtl/page_map_decoder.sv
module page_map_decoder
    import pmd_pkg::*;
#(
    parameter int VRAM_AW = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        cpu_addr,
    input  logic               cpu_fetch,
    input  logic               cpu_wr,
    input  logic               map_wr,
    input  logic [7:0]         map_wdata,
    input  logic               hires_wr,
    input  logic [7:0]         hires_wdata,
    input  logic               xmem_in,
    input  logic               kdtr_in,
    output logic [3:0]         dev_sel,
    output logic [VRAM_AW-1:0] mem_addr,
    output logic               mem_we
);

    logic [7:0] map_cur;
    ctl_t       ctl;
    logic [7:0] hires_cur;

    pmd_map_regfile #(.PAGES(16), .DW(8)) u_maps (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (map_wr),
        .idx   (cpu_addr[15:12]),
        .wdata (map_wdata),
        .cur   (map_cur)
    );

    pmd_ctrl_regs u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hires_wr    (hires_wr),
        .hires_wdata (hires_wdata),
        .xmem_in     (xmem_in),
        .kdtr_in     (kdtr_in),
        .ctl         (ctl)
    );

    pmd_decode #(.VRAM_AW(VRAM_AW)) u_dec (
        .addr    (cpu_addr),
        .fetch   (cpu_fetch),
        .wr      (cpu_wr),
        .map_cur (map_cur),
        .ctl     (ctl),
        .sel     (dev_sel),
        .maddr   (mem_addr),
        .we      (mem_we)
    );

    assign hires_cur = ctl.hires;

endmodule

// File: rtl/pmd_checker.sv
module pmd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cpu_fetch,
    input logic        hires_wr,
    input logic [7:0]  hires_wdata,
    input logic [7:0]  hires_cur,
    input logic [3:0]  dev_sel,
    input logic        mem_we
);

    // R9
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dev_sel) == 1);

    // R10
    rom_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_sel[0] |-> !mem_we);

    // R5
    fetch_no_chr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_fetch |-> !dev_sel[2]);

    // R3
    upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15] && !dev_sel[3]) |-> dev_sel[1]);

    // R6
    hires_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hires_wr |=> hires_cur == $past(hires_wdata));

endmodule

bind page_map_decoder pmd_checker u_pmd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_fetch   (cpu_fetch),
    .hires_wr    (hires_wr),
    .hires_wdata (hires_wdata),
    .hires_cur   (hires_cur),
    .dev_sel     (dev_sel),
    .mem_we      (mem_we)
);

// File: tb/test_page_map_decoder.sv
`timescale 1ns/1ps
module test_page_map_decoder;

    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cpu_addr = '0;
    logic          cpu_fetch = 1'b0;
    logic          cpu_wr = 1'b0;
    logic          map_wr = 1'b0;
    logic [7:0]    map_wdata = '0;
    logic          hires_wr = 1'b0;
    logic [7:0]    hires_wdata = '0;
    logic          xmem_in = 1'b0;
    logic          kdtr_in = 1'b1;
    logic [3:0]    dev_sel;
    logic [AW-1:0] mem_addr;
    logic          mem_we;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    page_map_decoder #(.VRAM_AW(AW)) i_page_map_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_fetch(cpu_fetch),
        .cpu_wr(cpu_wr), .map_wr(map_wr), .map_wdata(map_wdata),
        .hires_wr(hires_wr), .hires_wdata(hires_wdata), .xmem_in(xmem_in),
        .kdtr_in(kdtr_in), .dev_sel(dev_sel), .mem_addr(mem_addr), .mem_we(mem_we)
    );

    task automatic chk(input string tag, input logic [3:0] esel,
                       input logic [AW-1:0] eaddr, input logic ewe);
        n_tests++;
        if (dev_sel !== esel || mem_addr !== eaddr || mem_we !== ewe) begin
            n_fail++;
            $display("FAIL %s addr=%h: sel=%b maddr=%h we=%b expected sel=%b maddr=%h we=%b",
                     tag, cpu_addr, dev_sel, mem_addr, mem_we, esel, eaddr, ewe);
        end
    endtask

    task automatic access(input logic [15:0] a, input logic f, input logic w);
        @(negedge clk);
        cpu_addr = a; cpu_fetch = f; cpu_wr = w;
        #1;
    endtask

    task automatic write_map(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; map_wr = 1'b1; map_wdata = d;
        @(negedge clk);
        map_wr = 1'b0;
    endtask

    task automatic write_hires(input logic [7:0] d);
        @(negedge clk);
        hires_wr = 1'b1; hires_wdata = d;
        @(negedge clk);
        hires_wr = 1'b0;
    endtask

    task automatic t_reset;
        access(16'h0000, 0, 0);
        chk("R2 rom while in reset", 4'b0001, 17'h00000, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        access(16'h0000, 0, 0);
        chk("R2 rom after reset", 4'b0001, 17'h00000, 1'b0);
        access(16'h8000, 0, 0);
        chk("R2 ram after reset", 4'b0010, 17'h00000, 1'b0);
    endtask

    task automatic t_default;
        access(16'h1234, 0, 0);
        chk("R3 rom low", 4'b0001, 17'h01234, 1'b0);
        access(16'hFFFF, 0, 0);
        chk("R3 ram top", 4'b0010, 17'h07FFF, 1'b0);
        access(16'hA5C3, 1, 0);
        chk("R3 ram fetch", 4'b0010, 17'h025C3, 1'b0);
    endtask

    task automatic t_chr;
        access(16'h7800, 0, 0);
        chk("R4 chr start", 4'b0100, 17'h00000, 1'b0);
        access(16'h7FFF, 0, 1);
        chk("R4 chr end", 4'b0100, 17'h007FF, 1'b1);
        access(16'h77FF, 0, 0);
        chk("R4 below chr", 4'b0001, 17'h077FF, 1'b0);
    endtask

    task automatic t_fetch;
        access(16'h7A00, 1, 0);
        chk("R5 fetch in chr window", 4'b0001, 17'h07A00, 1'b0);
    endtask

    task automatic t_we;
        access(16'h0100, 0, 1);
        chk("R10 rom write blocked", 4'b0001, 17'h00100, 1'b0);
        access(16'h9000, 0, 1);
        chk("R10 ram write", 4'b0010, 17'h01000, 1'b1);
    endtask

    task automatic t_flat;
        write_hires(8'hA5);
        @(negedge clk); kdtr_in = 1'b0;
        access(16'h0123, 0, 1);
        chk("R6 flat video", 4'b1000, 17'h05123, 1'b1);
        access(16'h7800, 0, 0);
        chk("R6 flat beats chr", 4'b1000, 17'h07800, 1'b0);
        access(16'h9000, 0, 0);
        chk("R6 upper half ram", 4'b0010, 17'h01000, 1'b0);
        write_hires(8'hA0);
        access(16'h0123, 0, 0);
        chk("R11 low nibble ignored", 4'b1000, 17'h05123, 1'b0);
        @(negedge clk); kdtr_in = 1'b1;
    endtask

    task automatic t_paged;
        @(negedge clk); xmem_in = 1'b1;
        access(16'h3456, 0, 0);
        chk("R7 cleared reg disabled", 4'b0001, 17'h03456, 1'b0);
        @(negedge clk);
        cpu_addr = 16'h3456; map_wr = 1'b1; map_wdata = 8'h85;
        #1;
        chk("R1 old map during write", 4'b0001, 17'h03456, 1'b0);
        @(negedge clk); map_wr = 1'b0; #1;
        chk("R1 R8 new map paged masked", 4'b1000, 17'h1A456, 1'b0);
        write_map(16'hC000, 8'hF0);
        access(16'hC010, 0, 1);
        chk("R7 upper page remap", 4'b1000, 17'h0F010, 1'b1);
        write_map(16'h5000, 8'h12);
        access(16'h5000, 0, 0);
        chk("R7 bit7 clear disabled", 4'b0001, 17'h05000, 1'b0);
        @(negedge clk); kdtr_in = 1'b0;
        access(16'h3001, 0, 0);
        chk("R7 priority over flat", 4'b1000, 17'h1A001, 1'b0);
        access(16'h0010, 0, 0);
        chk("R6 flat on disabled page", 4'b1000, 17'h05010, 1'b0);
        @(negedge clk); xmem_in = 1'b0;
        access(16'hC010, 0, 0);
        chk("R7 xmem low no remap", 4'b0010, 17'h04010, 1'b0);
        @(negedge clk); kdtr_in = 1'b1;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_default();
        t_chr();
        t_fetch();
        t_we();
        t_flat();
        t_paged();
        repeat (2) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule